// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block compares two single-precision floating-point operands and captures the outcome in a one-bit condition flag. A branch unit can then test that flag for true or false. The caller picks the relation with a 2-bit condition select: equality, strictly-less, or less-or-equal. A compare strobe commits the result. The flag keeps its value until the next strobe.

Each operand is first decoded from its exponent and fraction fields. An all-zero exponent is taken as zero, so denormals are flushed. An all-ones exponent marks an infinity when the fraction is zero and a NaN when it is not. The sign, exponent and fraction are laid out so that the 31 magnitude bits order correctly as an unsigned integer. Ordering therefore uses a plain integer magnitude compare, with a correction for the signs. A NaN on either side makes the pair unordered, and every condition is then false.

Top module: `fp_compare_unit`

## Requirements
- R1: With select code 0 (equal), the flag becomes 1 exactly when neither operand is a NaN and both operands have the same numeric value. Otherwise it becomes 0.
- R2: With select code 1 (less-than), the flag becomes 1 exactly when neither operand is a NaN and operand A is numerically below operand B.
- R3: With select code 2 (less-or-equal), the flag becomes 1 exactly when neither operand is a NaN and operand A is below or equal to operand B.
- R4: Select code 3 is reserved and always yields a flag of 0.
- R5: An operand whose exponent is all ones and whose fraction is nonzero is a NaN. If either operand is a NaN, the flag becomes 0 for every select code.
- R6: An operand with an all-zero exponent is zero, whatever its fraction. Positive zero, negative zero and flushed denormals all compare equal to each other.
- R7: An all-ones exponent with a zero fraction is an infinity. Plus infinity is above every finite value, and minus infinity is below every finite value.
- R8: Any negative nonzero value compares below any positive value or zero. Between two negative values, the one with the larger magnitude is the smaller.
- R9: The flag takes the new result on the rising clock edge where the compare strobe is high. It holds unchanged on edges where the strobe is low.
- R10: The flag reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_a_i | input | 1+EXP_W+FRAC_W | Operand A: sign, exponent, fraction from MSB down |
| op_b_i | input | 1+EXP_W+FRAC_W | Operand B, same layout |
| cond_i | input | 2 | Condition select: 0 equal, 1 less-than, 2 less-or-equal, 3 reserved |
| cmp_i | input | 1 | Compare strobe; commits the result on this edge |
| flag_o | output | 1 | Registered condition flag |

## Verification
The assertions assume that the strobe, the select and the operands are stable across each rising edge. They also assume that reset is held for at least two edges, so that the internal release has completed before any compare. The bench drives all inputs on the falling edge and holds reset for several cycles. It then sweeps every pair of operands and every select code in a reduced format with a 3-bit exponent and a 2-bit fraction. Expected results come from real-valued arithmetic on the decoded operands. Between sweep blocks, the bench changes the operands with the strobe low to confirm that the flag holds.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  typedef enum logic [1:0] {
    CMP_EQ  = 2'd0,
    CMP_LT  = 2'd1,
    CMP_LE  = 2'd2,
    CMP_RSV = 2'd3
  } cmp_sel_e;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_i,
  output logic         nan_o,
  output logic [W-1:0] key_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_zero, exp_ones;

  assign exp_f    = op_i[W-2 -: EXP_W];
  assign frac_f   = op_i[FRAC_W-1:0];
  assign exp_zero = (exp_f == '0);
  assign exp_ones = (exp_f == '1);

  always_comb begin
    nan_o = exp_ones && (frac_f != '0);
    // zeros and denormals collapse to a single canonical +0
    key_o = exp_zero ? '0 : op_i;
  end

  // R6: a flushed operand never carries a sign or magnitude
  always_comb begin
    if (exp_zero) assert (key_o == '0) else $error("p_flush_zero_r6");
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] key_a_i,
  input  logic [W-1:0] key_b_i,
  output logic         eq_o,
  output logic         lt_o
);
  logic         sa, sb;
  logic [W-2:0] ma, mb;
  logic         mag_lt, mag_gt;

  assign sa     = key_a_i[W-1];
  assign sb     = key_b_i[W-1];
  assign ma     = key_a_i[W-2:0];
  assign mb     = key_b_i[W-2:0];
  assign mag_lt = (ma < mb);
  assign mag_gt = (ma > mb);

  always_comb begin
    eq_o = (key_a_i == key_b_i);
    if (sa != sb)  lt_o = sa;
    else if (!sa)  lt_o = mag_lt;
    else           lt_o = mag_gt;
  end

  // R3/R8: equal and strictly-less are never both true
  always_comb begin
    assert (!(eq_o && lt_o)) else $error("p_eq_lt_excl_r3");
  end
endmodule

// File: rtl/fp_compare_unit.sv
module fp_compare_unit #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic [1:0]   cond_i,
  input  logic         cmp_i,
  output logic         flag_o
);
  import fpcmp_pkg::*;

  logic [W-1:0] ops [2];
  logic [W-1:0] keys [2];
  logic [1:0]   nans;
  logic         eq_w, lt_w, unord, res_d;
  logic         flag_d, flag_q;
  logic [1:0]   rst_pipe_q;
  logic         rst_sync_n;

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op_i  (ops[g]),
      .nan_o (nans[g]),
      .key_o (keys[g])
    );
  end

  fpcmp_order #(.W(W)) u_ord (
    .key_a_i (keys[0]),
    .key_b_i (keys[1]),
    .eq_o    (eq_w),
    .lt_o    (lt_w)
  );

  assign unord = |nans;

  always_comb begin
    unique case (cmp_sel_e'(cond_i))
      CMP_EQ:  res_d = eq_w;
      CMP_LT:  res_d = lt_w;
      CMP_LE:  res_d = eq_w | lt_w;
      default: res_d = 1'b0;
    endcase
    if (unord) res_d = 1'b0;
  end

  always_comb begin
    flag_d = cmp_i ? res_d : flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) flag_q <= 1'b0;
    else             flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !cmp_i |=> $stable(flag_o));
  p_unordered_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (cmp_i && unord) |=> !flag_o);
  p_reserved_r4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (cmp_i && cond_i == 2'd3) |=> !flag_o);
  p_le_cover_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (cmp_i && cond_i == 2'd2 && !unord && (eq_w || lt_w)) |=> flag_o);
  p_reset_r10: assert property (@(posedge clk_i)
    !rst_sync_n |-> !flag_o);
endmodule

// File: tb/sim_fp_compare_unit.sv
module sim_fp_compare_unit;
  localparam int EW = 3;
  localparam int FW = 2;
  localparam int W  = 1 + EW + FW;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [1:0]   cond = '0;
  logic         cmp = 1'b0;
  logic         flag;
  int           n_chk = 0, n_fail = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  fp_compare_unit #(.EXP_W(EW), .FRAC_W(FW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(a), .op_b_i(b),
    .cond_i(cond), .cmp_i(cmp), .flag_o(flag)
  );

  function automatic bit is_nan(input logic [W-1:0] x);
    return (x[W-2 -: EW] == '1) && (x[FW-1:0] != 0);
  endfunction

  function automatic real value(input logic [W-1:0] x);
    int  e = int'(x[W-2 -: EW]);
    int  f = int'(x[FW-1:0]);
    real v;
    if (e == 0)                  v = 0.0;
    else if (e == (1 << EW) - 1) v = 1.0e30;
    else v = (1.0 + f / real'(1 << FW)) * (2.0 ** (e - ((1 << (EW - 1)) - 1)));
    return x[W-1] ? -v : v;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cond=%0d actual=%b expected=%b",
               tag, a, b, cond, act, exp_v);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic last;
    repeat (4) @(negedge clk);
    check("R10", flag, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", flag, 1'b0);

    for (int ia = 0; ia < (1 << W); ia++) begin
      for (int ib = 0; ib < (1 << W); ib++) begin
        for (int c = 0; c < 4; c++) begin
          real va, vb;
          bit  exp_v;
          string tag;
          a = ia[W-1:0]; b = ib[W-1:0]; cond = c[1:0]; cmp = 1'b1;
          va = value(a); vb = value(b);
          if (is_nan(a) || is_nan(b)) exp_v = 1'b0;
          else case (c)
            0: exp_v = (va == vb);
            1: exp_v = (va <  vb);
            2: exp_v = (va <= vb);
            default: exp_v = 1'b0;
          endcase
          if (is_nan(a) || is_nan(b))                          tag = "R5";
          else if (c == 3)                                     tag = "R4";
          else if (a[W-2 -: EW] == '1 || b[W-2 -: EW] == '1)   tag = "R7";
          else if (a[W-2 -: EW] == 0 && b[W-2 -: EW] == 0)     tag = "R6";
          else if (a[W-1] || b[W-1])                           tag = "R8";
          else if (c == 0)                                     tag = "R1";
          else if (c == 1)                                     tag = "R2";
          else                                                 tag = "R3";
          @(negedge clk);
          check(tag, flag, exp_v);
        end
      end
      // R9: strobe low with fresh operands must leave the flag alone
      last = flag;
      cmp = 1'b0; a = ~a; b = '0; cond = 2'd2;
      repeat (2) @(negedge clk);
      check("R9", flag, last);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule